// File: doc/BRIEF.md
# Programmable Periodic Tick Generator

This block turns a 32768 Hz timebase, delivered as a one-cycle enable pulse on the system clock, into periodic interrupt events at a rate chosen by a 4-bit rate code. It runs a 15-bit divider chain that is always counting. An event fires when that count crosses a multiple of the selected period. Events therefore stay aligned to the free-running count, and do not depend on when software wrote the rate.

Each event gives a one-cycle `event_pulse`, which the surrounding register file uses to set its periodic flag. The block also gives a request to set the interrupt flag, `irq_set_req`, which is raised only when the periodic enable is still high in the cycle the pulse appears. A 3-bit divider-control field can hold the chain in reset, and while it is held no events occur.

Top module: `periodic_tick_gen`

## Requirements
- R1: After reset both outputs are low and the chain is at zero. With rate code 3 and the enable set, the first event therefore follows exactly 4 timebase ticks after reset is released.
- R2: Rate code 0 produces no events and no interrupt requests.
- R3: For rate codes 3 to 15, consecutive events are exactly 2^(code-1) timebase ticks apart. The wrap of the 15-bit chain is itself a boundary.
- R4: Rate codes 1 and 2 behave like codes 8 and 9, giving 128 and 256 ticks between events.
- R5: An event occurs only in the cycle after the chain advances across a multiple of the current period. The time at which the rate was programmed has no effect on this.
- R6: An event is scheduled only if the periodic enable was high when the crossing tick was taken. `irq_set_req` is high only together with `event_pulse` and only while the enable is high in that same cycle. With the enable low, no events occur.
- R7: Divider-control values 110 and 111 (bits 2:1 both set) clear the chain to zero and suppress events. After release, the first event comes exactly one full period later. All other control values let the chain run normally.
- R8: A change of rate code creates no extra pulse. The next event falls on the next multiple of the new period.
- R9: The chain advances only on cycles with the timebase enable high, and each crossing produces a pulse of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per 32768 Hz timebase period |
| rate_sel | input | 4 | Periodic rate code (0 = off) |
| div_ctl | input | 3 | Divider control field; 11x holds the chain |
| pie_en | input | 1 | Periodic interrupt enable |
| event_pulse | output | 1 | One-cycle periodic event (sets the periodic flag) |
| irq_set_req | output | 1 | Request to set the interrupt flag |

## Verification
The assertions assume the inputs change only just after a rising clock edge. They also assume `tick_en` is a plain synchronous enable, so a cycle without it must not move the chain. The bench meets this by driving every input one nanosecond after the edge and sampling on the falling edge. It steps through every rate code, both hold patterns and a rapidly toggled enable. Its own model of the free-running count predicts, in every cycle, whether a pulse and an interrupt request are due.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

  // Codes at or below this limit alias onto slower rates.
  localparam int ALIAS_LIMIT = 2;
  // Amount added to an aliased code to get its period exponent.
  localparam int ALIAS_SHIFT = 6;

  // Divider-control pattern (bits 2:1) that holds the chain in reset.
  localparam logic [1:0] HOLD_PATTERN = 2'b11;

  function automatic logic chain_held(input logic [2:0] ctl);
    return ctl[2:1] == HOLD_PATTERN;
  endfunction

endpackage

// File: rtl/ptg_rate_decode.sv
module ptg_rate_decode #(
  parameter int CODE_W  = 4,
  parameter int CHAIN_W = 15,
  localparam int LOG_W  = $clog2(CHAIN_W + 1)
) (
  input  logic [CODE_W-1:0]  code,
  output logic               active,
  output logic [CHAIN_W-1:0] tap_mask
);
  import ptg_pkg::*;

  logic [LOG_W-1:0] log2p;

  always_comb begin
    active = (code != '0);
    if (code == '0) begin
      log2p = '0;
    end else if (code <= CODE_W'(ALIAS_LIMIT)) begin
      log2p = LOG_W'(code) + LOG_W'(ALIAS_SHIFT);
    end else begin
      log2p = LOG_W'(code) - LOG_W'(1);
    end
  end

  // One tap per chain bit: bit i is the carry source for period 2^(i+1).
  for (genvar i = 0; i < CHAIN_W; i++) begin : g_tap
    assign tap_mask[i] = active && (log2p == LOG_W'(i + 1));
  end

endmodule

// File: rtl/ptg_chain.sv
module ptg_chain #(
  parameter int CHAIN_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               hold,
  input  logic               sched_en,
  output logic [CHAIN_W-1:0] count_q,
  output logic [CHAIN_W-1:0] prev_q,
  output logic               step_q
);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      count_q <= '0;
      prev_q  <= '0;
      step_q  <= 1'b0;
    end else if (tick_en) begin
      prev_q  <= count_q;
      count_q <= count_q + CHAIN_W'(1);
      step_q  <= sched_en;
    end else begin
      step_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/ptg_tap_edge.sv
module ptg_tap_edge #(
  parameter int CHAIN_W = 15
) (
  input  logic               step_q,
  input  logic [CHAIN_W-1:0] prev_q,
  input  logic [CHAIN_W-1:0] count_q,
  input  logic [CHAIN_W-1:0] tap_mask,
  output logic               fire
);
  logic [CHAIN_W-1:0] fell;

  // A tap bit going 1 -> 0 is the carry out of that stage.
  assign fell = prev_q & ~count_q;
  assign fire = step_q & (|(fell & tap_mask));

endmodule

// File: rtl/periodic_tick_gen.sv
module periodic_tick_gen #(
  parameter int CODE_W  = 4,
  parameter int CHAIN_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] rate_sel,
  input  logic [2:0]        div_ctl,
  input  logic              pie_en,
  output logic              event_pulse,
  output logic              irq_set_req
);
  import ptg_pkg::*;

  logic               active;
  logic [CHAIN_W-1:0] tap_mask;
  logic [CHAIN_W-1:0] count_q;
  logic [CHAIN_W-1:0] prev_q;
  logic               step_q;
  logic               hold;
  logic               sched_en;

  assign hold     = chain_held(div_ctl);
  assign sched_en = pie_en & active;

  ptg_rate_decode #(.CODE_W(CODE_W), .CHAIN_W(CHAIN_W)) u_decode (
    .code     (rate_sel),
    .active   (active),
    .tap_mask (tap_mask)
  );

  ptg_chain #(.CHAIN_W(CHAIN_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .hold     (hold),
    .sched_en (sched_en),
    .count_q  (count_q),
    .prev_q   (prev_q),
    .step_q   (step_q)
  );

  ptg_tap_edge #(.CHAIN_W(CHAIN_W)) u_edge (
    .step_q   (step_q),
    .prev_q   (prev_q),
    .count_q  (count_q),
    .tap_mask (tap_mask),
    .fire     (event_pulse)
  );

  assign irq_set_req = event_pulse & pie_en;

endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
  parameter int CODE_W  = 4,
  parameter int CHAIN_W = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_en,
  input logic [CODE_W-1:0]  rate_sel,
  input logic [2:0]         div_ctl,
  input logic               pie_en,
  input logic               event_pulse,
  input logic               irq_set_req,
  input logic [CHAIN_W-1:0] count_q
);

  // R9: every pulse lasts one cycle
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    event_pulse |=> !event_pulse);

  // R9: no pulse without a timebase tick on the edge before
  p_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick_en) |-> !event_pulse);

  // R5: a pulse always coincides with an advance of the chain
  p_event_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    event_pulse |-> (count_q != $past(count_q)));

  // R6: an interrupt request needs the enable at the crossing tick
  p_irq_pie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_req |-> $past(pie_en));

  // R2: rate code 0 at the crossing tick yields no request
  p_zero_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rate_sel == '0) |-> !irq_set_req);

  // R7: a held chain sits at zero and stays quiet
  p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(div_ctl[2:1] == 2'b11) |-> (count_q == '0));

  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(div_ctl[2:1] == 2'b11) |-> !event_pulse);

endmodule

bind periodic_tick_gen ptg_checker #(.CODE_W(CODE_W), .CHAIN_W(CHAIN_W)) u_ptg_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .rate_sel    (rate_sel),
  .div_ctl     (div_ctl),
  .pie_en      (pie_en),
  .event_pulse (event_pulse),
  .irq_set_req (irq_set_req),
  .count_q     (count_q)
);

// File: tb/test_periodic_tick_gen.sv
module test_periodic_tick_gen;
  localparam int CW = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic [2:0] div_ctl = 3'b010;
  logic       pie_en = 1'b0;
  logic       event_pulse;
  logic       irq_set_req;

  int tests = 0;
  int fails = 0;
  int tick_mode = 1;
  int ev_total = 0;
  int ev_irq = 0;
  int ev_noirq = 0;
  bit skip_next = 0;
  string cur_tag = "R5";
  int    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  periodic_tick_gen i_periodic_tick_gen (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_sel(rate_sel),
    .div_ctl(div_ctl), .pie_en(pie_en), .event_pulse(event_pulse),
    .irq_set_req(irq_set_req)
  );

  function automatic int period_log2(input int code);
    if (code == 0) return 0;
    if (code <= 2) return code + 6;
    return code - 1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Timebase enable generator
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk); #1;
      ph++;
      tick_en = (tick_mode == 1) || (tick_mode == 3 && (ph % 3) == 0);
    end
  end

  // Monitor: reference count model plus interval scoreboard
  int m_abs = 0, m_prev = 0, ticks_since = 0;
  bit m_step = 0, t_s = 0, hold_s = 0, pie_s = 0;
  int rate_s = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      m_abs = 0; m_prev = 0; m_step = 0; ticks_since = 0;
      t_s = 0; hold_s = 0; pie_s = 0; rate_s = 0;
    end else begin
      int  k;
      bit  exp_ev, exp_irq;
      if (hold_s) begin
        m_abs = 0; m_prev = 0; m_step = 0;
      end else if (t_s) begin
        m_prev = m_abs;
        m_abs  = (m_abs + 1) % (1 << CW);
        m_step = pie_s && (rate_s != 0);
      end else begin
        m_step = 0;
      end
      k = period_log2(int'(rate_sel));
      exp_ev = m_step && (k > 0) && (((m_prev >> (k - 1)) & 1) == 1)
               && (((m_abs >> (k - 1)) & 1) == 0);
      exp_irq = exp_ev && pie_en;
      if (exp_ev || event_pulse)
        check(event_pulse == exp_ev, cur_tag, int'(event_pulse), int'(exp_ev));
      if (exp_irq || irq_set_req)
        check(irq_set_req == exp_irq, "R6", int'(irq_set_req), int'(exp_irq));
      if (event_pulse) begin
        ev_total++;
        if (irq_set_req) ev_irq++; else ev_noirq++;
        if (skip_next) skip_next = 0;
        else if (exp_q.size() != 0) begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(ticks_since == e, t, ticks_since, e);
        end
        ticks_since = 0;
      end
      if (div_ctl[2:1] == 2'b11) ticks_since = 0;
      else if (tick_en) ticks_since++;
      t_s = tick_en; hold_s = (div_ctl[2:1] == 2'b11); pie_s = pie_en; rate_s = int'(rate_sel);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    #1;
  endtask

  task automatic measure(input int code, input int period, input string tag, input int n);
    step(1);
    rate_sel = 4'(code);
    skip_next = 1;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(period);
      tag_q.push_back(tag);
    end
    drain();
  endtask

  initial begin
    int snap;
    // R1: reset state and first event from zero
    rate_sel = 4'd3; pie_en = 1'b1;
    step(3);
    check(event_pulse == 1'b0 && irq_set_req == 1'b0, "R1", int'(event_pulse), 0);
    exp_q.push_back(4); tag_q.push_back("R1");
    rst_n = 1'b1;
    drain();

    // R3: every plain code
    for (int c = 3; c <= 15; c++) measure(c, 1 << (c - 1), "R3", 1);

    // R4: aliased codes, sparse ticks (R9 pulse shape via model)
    tick_mode = 3; cur_tag = "R9";
    measure(1, 128, "R4", 2);
    measure(2, 256, "R4", 2);
    tick_mode = 1; cur_tag = "R5";

    // R2: code 0 is silent
    step(1); rate_sel = 4'd0; step(2); snap = ev_total;
    step(600);
    check(ev_total == snap, "R2", ev_total - snap, 0);

    // R6: enable low stops scheduling
    rate_sel = 4'd3; pie_en = 1'b0; step(2); snap = ev_total;
    step(200);
    check(ev_total == snap, "R6", ev_total - snap, 0);
    snap = ev_noirq;
    for (int i = 0; i < 400; i++) begin
      step(1); pie_en = (i % 3) != 0;
    end
    pie_en = 1'b1;
    check(ev_noirq > snap, "R6", ev_noirq - snap, 1);
    check(ev_irq > 0, "R6", ev_irq, 1);

    // R7: hold patterns, then exact first period after release
    cur_tag = "R7";
    measure(5, 16, "R7", 1);
    step(7); div_ctl = 3'b110; step(2); snap = ev_total;
    step(100);
    check(ev_total == snap, "R7", ev_total - snap, 0);
    exp_q.push_back(16); tag_q.push_back("R7");
    div_ctl = 3'b010; drain();
    step(5); div_ctl = 3'b111; step(2); snap = ev_total;
    step(100);
    check(ev_total == snap, "R7", ev_total - snap, 0);
    exp_q.push_back(16); tag_q.push_back("R7");
    div_ctl = 3'b000; drain();
    div_ctl = 3'b101;
    measure(4, 8, "R7", 2);
    div_ctl = 3'b010;

    // R8: rate changes mid-period, model checks alignment
    cur_tag = "R8";
    measure(6, 32, "R8", 1);
    step(11); rate_sel = 4'd10; snap = ev_total;
    step(1100);
    check(ev_total - snap >= 2, "R8", ev_total - snap, 2);
    step(37); rate_sel = 4'd3;
    step(1);
    exp_q.push_back(4); tag_q.push_back("R8");
    skip_next = 1;
    drain();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule